// File: doc/BRIEF.md
# Two-Dimensional Leapfrog Field Stencil Engine

This block advances a small two-dimensional electromagnetic field simulation that lives entirely in on-chip storage. The grid holds two electric field components (Ex, Ey) and one magnetic component (Hz), all in signed Q2.13 fixed point. Each iteration has four parts, in this order:

1. An electric sweep updates Ex and Ey from Hz.
2. A magnetic sweep updates Hz from the fresh Ex and Ey.
3. A point source sample is added to Hz at one chosen cell.
4. An energy sweep adds the square of every cell's Hz to a 40-bit running sum for that cell.

A per-cell mask selects which interior cells the stencil sweeps may rewrite.

Software loads four coefficients, the source cell and an iteration count, then pulses start. At the beginning of each iteration the engine raises a ready flag and waits for a valid source amplitude. When the last iteration ends it pulses done. Fields and sums can be read back through a registered read port. Field state carries over from one run to the next, so a long simulation can be split into several runs.

Top module: `fdtd_engine`

## Requirements
- R1: After reset, every Ex, Ey, Hz value and every energy sum is 0, every mask bit is 1, and busy, done, src_ready and rd_valid are all low.
- R2: In the electric sweep, each updated interior cell i (with C = COLS) is computed as follows, using the Hz values from before the iteration:
  - Ex[i] becomes rs(ca·Ex[i] + cb·(Hz[i] − Hz[i−C])).
  - Ey[i] becomes rs(ca·Ey[i] + cb·(Hz[i−1] − Hz[i])).
  - rs(a) takes the exact sum a, adds 4096, shifts right arithmetically by 13 and clamps the result to [−32768, 32767].
- R3: In the magnetic sweep, each updated interior cell becomes Hz[i] = rs(da·Hz[i] + db·(Ex[i+C] − Ex[i] + Ey[i] − Ey[i+1])), using the Ex and Ey values produced in the same iteration.
- R4: Only interior cells (row 1 to ROWS−2 and column 1 to COLS−2, with cell index row·COLS+col) are changed by the stencil sweeps. Border cells keep their values.
- R5: An interior cell whose mask bit is 0 keeps all three field values. A mask write (mask_we with mask_addr and mask_bit) takes effect only while busy is low and is ignored while busy is high.
- R6: Before each iteration the engine holds src_ready high and waits, for any number of cycles, until src_valid is high. It then samples src_data. After the magnetic sweep it adds that sample to Hz at cell src_row·COLS+src_col, clamping to [−32768, 32767]. This addition applies whatever the cell's mask bit and whether or not the cell is interior.
- R7: After the source is injected, every cell's 40-bit energy sum grows by the square of its Hz value.
- R8: A run performs exactly iter_count iterations and then raises done for one cycle, in the cycle where busy falls. With iter_count = 0, done pulses in the cycle after start and no field changes.
- R9: The coefficients and the source cell are captured at an accepted start. Changes to those inputs, and further start pulses, are ignored while busy.
- R10: A read request (rd_en) returns its result on rd_data, with rd_valid high, one cycle later. The rd_sel encoding is 0 = Ex, 1 = Ey, 2 = Hz, 3 = energy sum. Field values are sign-extended to 40 bits.
- R11: Starting a run does not clear the fields or the sums. Each run continues from the state left by the previous run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (accepted when idle) |
| iter_count | input | ITER_W | Number of iterations in the run |
| coef_ca | input | 16 | Electric self coefficient, Q2.13 |
| coef_cb | input | 16 | Electric curl coefficient, Q2.13 |
| coef_da | input | 16 | Magnetic self coefficient, Q2.13 |
| coef_db | input | 16 | Magnetic curl coefficient, Q2.13 |
| src_row | input | RW | Source cell row |
| src_col | input | CW | Source cell column |
| mask_we | input | 1 | Mask write strobe |
| mask_addr | input | AW | Mask cell index |
| mask_bit | input | 1 | Mask value to write |
| src_valid | input | 1 | Source amplitude valid |
| src_data | input | 16 | Source amplitude, Q2.13 |
| src_ready | output | 1 | Engine waits for a source amplitude |
| rd_en | input | 1 | Read request |
| rd_sel | input | 2 | Array select for the read |
| rd_addr | input | AW | Cell index for the read |
| rd_data | output | 40 | Read result |
| rd_valid | output | 1 | Read result valid |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The situations hardest to reach from the ports are clamping inside the stencil and clamping at the injected cell. Fields start at zero, so these only appear after several coupled iterations with large coefficients and near-full-scale source samples. The bench therefore aims two successive 30000 samples at a corner cell, uses coefficients close to 4.0, and compares every cell of every array against an arithmetic model. Mid-run interference is also hard to reach: the bench stalls the source handshake, and it issues a mask write, coefficient changes and a second start while busy, so that the order of sweeps and the ignored inputs are all visible in the final state.

// File: rtl/fdtd_pkg.sv
package fdtd_pkg;
  localparam int DATA_W = 16;
  localparam int FRAC_W = 13;
  localparam int EN_W   = 40;
  localparam int WIDE_W = 40;

  typedef enum logic [2:0] {
    PH_IDLE, PH_WAIT, PH_E, PH_H, PH_INJ, PH_EN
  } phase_t;

  function automatic logic signed [DATA_W-1:0] sat_data(input logic signed [WIDE_W-1:0] v);
    logic signed [WIDE_W-1:0] one, hi, lo;
    one = WIDE_W'(1);
    hi  = (one <<< (DATA_W-1)) - one;
    lo  = -hi - one;
    if (v > hi)      return hi[DATA_W-1:0];
    else if (v < lo) return lo[DATA_W-1:0];
    else             return v[DATA_W-1:0];
  endfunction

  function automatic logic signed [DATA_W-1:0] round_sat(input logic signed [WIDE_W-1:0] acc);
    logic signed [WIDE_W-1:0] half, t;
    half = WIDE_W'(1) <<< (FRAC_W-1);
    t    = (acc + half) >>> FRAC_W;
    return sat_data(t);
  endfunction
endpackage

// File: rtl/fdtd_cell_store.sv
module fdtd_cell_store #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 256,
  parameter int NRD   = 1,
  parameter int AW    = $clog2(DEPTH),
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [AW-1:0]        waddr,
  input  logic [WIDTH-1:0]     wdata,
  input  logic [NRD*AW-1:0]    raddr,
  output logic [NRD*WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= RST_VAL;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p*WIDTH +: WIDTH] =
      (int'(raddr[p*AW +: AW]) < DEPTH) ? mem[raddr[p*AW +: AW]] : '0;
  end
endmodule

// File: rtl/fdtd_cell_alu.sv
module fdtd_cell_alu import fdtd_pkg::*; (
  input  logic signed [DATA_W-1:0] ca,
  input  logic signed [DATA_W-1:0] cb,
  input  logic signed [DATA_W-1:0] da,
  input  logic signed [DATA_W-1:0] db,
  input  logic signed [DATA_W-1:0] hz_c,
  input  logic signed [DATA_W-1:0] hz_up,
  input  logic signed [DATA_W-1:0] hz_lf,
  input  logic signed [DATA_W-1:0] ex_c,
  input  logic signed [DATA_W-1:0] ex_dn,
  input  logic signed [DATA_W-1:0] ey_c,
  input  logic signed [DATA_W-1:0] ey_rt,
  input  logic signed [DATA_W-1:0] amp,
  input  logic [EN_W-1:0]          en_c,
  output logic signed [DATA_W-1:0] ex_new,
  output logic signed [DATA_W-1:0] ey_new,
  output logic signed [DATA_W-1:0] hz_new,
  output logic signed [DATA_W-1:0] hz_inj,
  output logic [EN_W-1:0]          en_new
);
  logic signed [WIDE_W-1:0] ex_acc, ey_acc, hz_acc, curl_h, sq;

  always_comb begin
    ex_acc = WIDE_W'(ca) * WIDE_W'(ex_c) + WIDE_W'(cb) * (WIDE_W'(hz_c) - WIDE_W'(hz_up));
    ey_acc = WIDE_W'(ca) * WIDE_W'(ey_c) + WIDE_W'(cb) * (WIDE_W'(hz_lf) - WIDE_W'(hz_c));
    curl_h = WIDE_W'(ex_dn) - WIDE_W'(ex_c) + WIDE_W'(ey_c) - WIDE_W'(ey_rt);
    hz_acc = WIDE_W'(da) * WIDE_W'(hz_c) + WIDE_W'(db) * curl_h;
    sq     = WIDE_W'(hz_c) * WIDE_W'(hz_c);
    ex_new = round_sat(ex_acc);
    ey_new = round_sat(ey_acc);
    hz_new = round_sat(hz_acc);
    hz_inj = sat_data(WIDE_W'(hz_c) + WIDE_W'(amp));
    en_new = en_c + $unsigned(sq);
  end
endmodule

// File: rtl/fdtd_sweep_ctrl.sv
module fdtd_sweep_ctrl import fdtd_pkg::*; #(
  parameter int ROWS   = 16,
  parameter int COLS   = 16,
  parameter int ITER_W = 16,
  parameter int RW     = $clog2(ROWS),
  parameter int CW     = $clog2(COLS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [ITER_W-1:0]        iter_count,
  input  logic                     src_valid,
  input  logic signed [DATA_W-1:0] src_data,
  output logic                     src_ready,
  output phase_t                   phase,
  output logic [RW-1:0]            row,
  output logic [CW-1:0]            col,
  output logic signed [DATA_W-1:0] amp,
  output logic                     busy,
  output logic                     done
);
  localparam logic [RW-1:0] ROW_MAX = RW'(ROWS-1);
  localparam logic [CW-1:0] COL_MAX = CW'(COLS-1);

  logic [ITER_W-1:0] left;
  logic last_cell;

  assign last_cell = (row == ROW_MAX) && (col == COL_MAX);
  assign busy      = (phase != PH_IDLE);
  assign src_ready = (phase == PH_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      row   <= '0;
      col   <= '0;
      left  <= '0;
      amp   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (start) begin
            if (iter_count == '0) done <= 1'b1;
            else begin
              left  <= iter_count;
              phase <= PH_WAIT;
            end
          end
        end
        PH_WAIT: begin
          if (src_valid) begin
            amp   <= src_data;
            row   <= '0;
            col   <= '0;
            phase <= PH_E;
          end
        end
        PH_E, PH_H, PH_EN: begin
          if (last_cell) begin
            row <= '0;
            col <= '0;
            if (phase == PH_E) phase <= PH_H;
            else if (phase == PH_H) phase <= PH_INJ;
            else if (left == ITER_W'(1)) begin
              phase <= PH_IDLE;
              done  <= 1'b1;
            end else begin
              left  <= left - ITER_W'(1);
              phase <= PH_WAIT;
            end
          end else if (col == COL_MAX) begin
            col <= '0;
            row <= row + RW'(1);
          end else begin
            col <= col + CW'(1);
          end
        end
        PH_INJ:  phase <= PH_EN;
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fdtd_engine.sv
module fdtd_engine import fdtd_pkg::*; #(
  parameter int ROWS   = 16,
  parameter int COLS   = 16,
  parameter int ITER_W = 16,
  parameter int AW     = $clog2(ROWS*COLS),
  parameter int RW     = $clog2(ROWS),
  parameter int CW     = $clog2(COLS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [ITER_W-1:0]        iter_count,
  input  logic signed [DATA_W-1:0] coef_ca,
  input  logic signed [DATA_W-1:0] coef_cb,
  input  logic signed [DATA_W-1:0] coef_da,
  input  logic signed [DATA_W-1:0] coef_db,
  input  logic [RW-1:0]            src_row,
  input  logic [CW-1:0]            src_col,
  input  logic                     mask_we,
  input  logic [AW-1:0]            mask_addr,
  input  logic                     mask_bit,
  input  logic                     src_valid,
  input  logic signed [DATA_W-1:0] src_data,
  output logic                     src_ready,
  input  logic                     rd_en,
  input  logic [1:0]               rd_sel,
  input  logic [AW-1:0]            rd_addr,
  output logic [EN_W-1:0]          rd_data,
  output logic                     rd_valid,
  output logic                     busy,
  output logic                     done
);
  localparam int CELLS = ROWS * COLS;
  localparam logic [RW-1:0] R_LO = RW'(1);
  localparam logic [RW-1:0] R_HI = RW'(ROWS-2);
  localparam logic [CW-1:0] C_LO = CW'(1);
  localparam logic [CW-1:0] C_HI = CW'(COLS-2);

  phase_t phase;
  logic [RW-1:0] row, src_row_q;
  logic [CW-1:0] col, src_col_q;
  logic signed [DATA_W-1:0] amp, ca_q, cb_q, da_q, db_q;

  fdtd_sweep_ctrl #(.ROWS(ROWS), .COLS(COLS), .ITER_W(ITER_W), .RW(RW), .CW(CW)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .iter_count(iter_count),
    .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
    .phase(phase), .row(row), .col(col), .amp(amp), .busy(busy), .done(done)
  );

  // capture run settings on an accepted start
  always_ff @(posedge clk) begin
    if (rst) begin
      ca_q <= '0; cb_q <= '0; da_q <= '0; db_q <= '0;
      src_row_q <= '0; src_col_q <= '0;
    end else if (start && !busy) begin
      ca_q <= coef_ca; cb_q <= coef_cb; da_q <= coef_da; db_q <= coef_db;
      src_row_q <= src_row; src_col_q <= src_col;
    end
  end

  logic [AW-1:0] cur, cur_up, cur_dn, cur_lf, cur_rt, src_idx, hz_a0;
  logic interior, inj;

  assign cur      = AW'(row) * AW'(COLS) + AW'(col);
  assign cur_up   = cur - AW'(COLS);
  assign cur_dn   = cur + AW'(COLS);
  assign cur_lf   = cur - AW'(1);
  assign cur_rt   = cur + AW'(1);
  assign src_idx  = AW'(src_row_q) * AW'(COLS) + AW'(src_col_q);
  assign interior = (row >= R_LO) && (row <= R_HI) && (col >= C_LO) && (col <= C_HI);
  assign inj      = (phase == PH_INJ);
  assign hz_a0    = inj ? src_idx : cur;

  logic [4*DATA_W-1:0] hz_rdata;
  logic [3*DATA_W-1:0] ex_rdata, ey_rdata;
  logic [2*EN_W-1:0]   en_rdata;
  logic                mask_cur;
  logic signed [DATA_W-1:0] hz_c, hz_up, hz_lf, hz_rd, ex_c, ex_dn, ex_rd, ey_c, ey_rt, ey_rd;
  logic [EN_W-1:0] en_c, en_rd;
  logic signed [DATA_W-1:0] ex_new, ey_new, hz_new, hz_inj;
  logic [EN_W-1:0] en_new;
  logic ex_we, ey_we, hz_we, en_we, upd;

  assign upd   = interior && mask_cur;
  assign ex_we = (phase == PH_E) && upd;
  assign ey_we = ex_we;
  assign hz_we = ((phase == PH_H) && upd) || inj;
  assign en_we = (phase == PH_EN);

  fdtd_cell_store #(.WIDTH(DATA_W), .DEPTH(CELLS), .NRD(4), .AW(AW)) u_hz (
    .clk(clk), .rst(rst), .we(hz_we), .waddr(hz_a0),
    .wdata(inj ? hz_inj : hz_new),
    .raddr({rd_addr, cur_lf, cur_up, hz_a0}), .rdata(hz_rdata)
  );
  fdtd_cell_store #(.WIDTH(DATA_W), .DEPTH(CELLS), .NRD(3), .AW(AW)) u_ex (
    .clk(clk), .rst(rst), .we(ex_we), .waddr(cur), .wdata(ex_new),
    .raddr({rd_addr, cur_dn, cur}), .rdata(ex_rdata)
  );
  fdtd_cell_store #(.WIDTH(DATA_W), .DEPTH(CELLS), .NRD(3), .AW(AW)) u_ey (
    .clk(clk), .rst(rst), .we(ey_we), .waddr(cur), .wdata(ey_new),
    .raddr({rd_addr, cur_rt, cur}), .rdata(ey_rdata)
  );
  fdtd_cell_store #(.WIDTH(EN_W), .DEPTH(CELLS), .NRD(2), .AW(AW)) u_en (
    .clk(clk), .rst(rst), .we(en_we), .waddr(cur), .wdata(en_new),
    .raddr({rd_addr, cur}), .rdata(en_rdata)
  );
  fdtd_cell_store #(.WIDTH(1), .DEPTH(CELLS), .NRD(1), .AW(AW), .RST_VAL(1'b1)) u_mask (
    .clk(clk), .rst(rst), .we(mask_we && !busy), .waddr(mask_addr), .wdata(mask_bit),
    .raddr(cur), .rdata(mask_cur)
  );

  assign hz_c  = hz_rdata[0*DATA_W +: DATA_W];
  assign hz_up = hz_rdata[1*DATA_W +: DATA_W];
  assign hz_lf = hz_rdata[2*DATA_W +: DATA_W];
  assign hz_rd = hz_rdata[3*DATA_W +: DATA_W];
  assign ex_c  = ex_rdata[0*DATA_W +: DATA_W];
  assign ex_dn = ex_rdata[1*DATA_W +: DATA_W];
  assign ex_rd = ex_rdata[2*DATA_W +: DATA_W];
  assign ey_c  = ey_rdata[0*DATA_W +: DATA_W];
  assign ey_rt = ey_rdata[1*DATA_W +: DATA_W];
  assign ey_rd = ey_rdata[2*DATA_W +: DATA_W];
  assign en_c  = en_rdata[0 +: EN_W];
  assign en_rd = en_rdata[EN_W +: EN_W];

  fdtd_cell_alu u_alu (
    .ca(ca_q), .cb(cb_q), .da(da_q), .db(db_q),
    .hz_c(hz_c), .hz_up(hz_up), .hz_lf(hz_lf),
    .ex_c(ex_c), .ex_dn(ex_dn), .ey_c(ey_c), .ey_rt(ey_rt),
    .amp(amp), .en_c(en_c),
    .ex_new(ex_new), .ey_new(ey_new), .hz_new(hz_new), .hz_inj(hz_inj), .en_new(en_new)
  );

  // registered read port
  logic [EN_W-1:0] rd_next;
  always_comb begin
    case (rd_sel)
      2'd0:    rd_next = EN_W'(ex_rd);
      2'd1:    rd_next = EN_W'(ey_rd);
      2'd2:    rd_next = EN_W'(hz_rd);
      default: rd_next = en_rd;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_next;
    end
  end
endmodule

// File: rtl/fdtd_engine_chk.sv
module fdtd_engine_chk #(
  parameter int ITER_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [ITER_W-1:0] iter_count,
  input logic              busy,
  input logic              done,
  input logic              src_ready,
  input logic              rd_en,
  input logic              rd_valid
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!busy && !done && !src_ready && !rd_valid));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_zero_iter_R8: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && iter_count == '0) |=> (done && !busy));

  assert_start_busy_R9: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && iter_count != '0) |=> busy);

  assert_ready_in_run_R6: assert property (@(posedge clk) disable iff (rst)
    src_ready |-> busy);

  assert_rd_latency_R10: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  assert_rd_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);
endmodule

bind fdtd_engine fdtd_engine_chk #(.ITER_W(ITER_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .iter_count(iter_count),
  .busy(busy), .done(done), .src_ready(src_ready),
  .rd_en(rd_en), .rd_valid(rd_valid)
);

// File: tb/fdtd_engine_test.sv
module fdtd_engine_test;
  localparam int ROWS = 16, COLS = 16, CELLS = ROWS*COLS, AW = 8, ITER_W = 16;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [ITER_W-1:0] iter_count = '0;
  logic signed [15:0] coef_ca = '0, coef_cb = '0, coef_da = '0, coef_db = '0;
  logic [3:0] src_row = '0, src_col = '0;
  logic mask_we = 1'b0, mask_bit = 1'b0;
  logic [AW-1:0] mask_addr = '0, rd_addr = '0;
  logic src_valid, src_ready, rd_en = 1'b0, rd_valid, busy, done;
  logic signed [15:0] src_data;
  logic [1:0] rd_sel = '0;
  logic [39:0] rd_data;

  fdtd_engine #(.ROWS(ROWS), .COLS(COLS), .ITER_W(ITER_W)) uut (
    .clk(clk), .rst(rst), .start(start), .iter_count(iter_count),
    .coef_ca(coef_ca), .coef_cb(coef_cb), .coef_da(coef_da), .coef_db(coef_db),
    .src_row(src_row), .src_col(src_col), .mask_we(mask_we), .mask_addr(mask_addr),
    .mask_bit(mask_bit), .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_valid(rd_valid), .busy(busy), .done(done)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0, done_cnt = 0;
  int amps [16];
  int amp_idx = 0, m_amp_idx = 0;
  logic feed_en = 1'b1;
  assign src_valid = feed_en;
  assign src_data  = 16'(amps[amp_idx]);

  always @(posedge clk) if (src_valid && src_ready) amp_idx <= amp_idx + 1;
  always @(negedge clk) if (done) done_cnt++;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung (act cycles %0d, exp < 150000)", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // model state
  longint m_ex [CELLS], m_ey [CELLS], m_hz [CELLS], m_en [CELLS];
  bit m_mask [CELLS];
  longint mca, mcb, mda, mdb;
  int msrc;

  function automatic longint clamp16(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic longint rsat(longint acc);
    return clamp16((acc + 4096) >>> 13);
  endfunction

  task automatic model_iter(longint amp);
    for (int r = 1; r <= ROWS-2; r++)
      for (int c = 1; c <= COLS-2; c++) begin
        int i = r*COLS + c;
        if (m_mask[i]) begin
          m_ex[i] = rsat(mca*m_ex[i] + mcb*(m_hz[i] - m_hz[i-COLS]));
          m_ey[i] = rsat(mca*m_ey[i] + mcb*(m_hz[i-1] - m_hz[i]));
        end
      end
    for (int r = 1; r <= ROWS-2; r++)
      for (int c = 1; c <= COLS-2; c++) begin
        int i = r*COLS + c;
        if (m_mask[i])
          m_hz[i] = rsat(mda*m_hz[i] + mdb*(m_ex[i+COLS] - m_ex[i] + m_ey[i] - m_ey[i+1]));
      end
    m_hz[msrc] = clamp16(m_hz[msrc] + amp);
    for (int i = 0; i < CELLS; i++) m_en[i] = m_en[i] + m_hz[i]*m_hz[i];
  endtask

  task automatic model_run(int n);
    for (int k = 0; k < n; k++) begin
      model_iter(longint'(amps[m_amp_idx]));
      m_amp_idx++;
    end
  endtask

  task automatic check(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic rd(input int sel, input int addr, output logic [39:0] v);
    @(negedge clk);
    rd_en = 1'b1; rd_sel = 2'(sel); rd_addr = AW'(addr);
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic compare_all(string tag);
    logic [39:0] v, e;
    for (int s = 0; s < 4; s++)
      for (int i = 0; i < CELLS; i++) begin
        rd(s, i, v);
        case (s)
          0: e = 40'(m_ex[i]);
          1: e = 40'(m_ey[i]);
          2: e = 40'(m_hz[i]);
          default: e = 40'(m_en[i]);
        endcase
        check(v === e, $sformatf("%s sel %0d cell %0d", tag, s, i), longint'(v), longint'(e));
      end
  endtask

  task automatic set_run(int ca, int cb, int da, int db, int sr, int sc);
    coef_ca = 16'(ca); coef_cb = 16'(cb); coef_da = 16'(da); coef_db = 16'(db);
    src_row = 4'(sr); src_col = 4'(sc);
    mca = ca; mcb = cb; mda = da; mdb = db; msrc = sr*COLS + sc;
  endtask

  task automatic start_run(int n);
    @(negedge clk);
    iter_count = ITER_W'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(int d0);
    while (done_cnt == d0) @(negedge clk);
  endtask

  task automatic load_mask(int addr, bit b);
    @(negedge clk);
    mask_we = 1'b1; mask_addr = AW'(addr); mask_bit = b;
    @(negedge clk);
    mask_we = 1'b0;
    if (!busy) m_mask[addr] = b;
  endtask

  initial begin
    int d0;
    logic [39:0] v;
    amps = '{8192, -4000, 12000, 5000, -7000, 3000, 9000, -2500,
             30000, 30000, 1000, 2000, 3000, 4000, 5000, 6000};
    for (int i = 0; i < CELLS; i++) begin
      m_ex[i] = 0; m_ey[i] = 0; m_hz[i] = 0; m_en[i] = 0; m_mask[i] = 1'b1;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: idle outputs and cleared arrays
    check(busy == 1'b0 && done == 1'b0 && src_ready == 1'b0, "R1 idle outputs",
          longint'({busy, done, src_ready}), 0);
    compare_all("R1 reset contents");

    // R10: read latency and valid
    @(negedge clk); rd_en = 1'b1; rd_sel = 2'd2; rd_addr = 8'd0;
    @(negedge clk); rd_en = 1'b0;
    check(rd_valid == 1'b1, "R10 rd_valid one cycle after request", longint'(rd_valid), 1);
    @(negedge clk);
    check(rd_valid == 1'b0, "R10 rd_valid low without request", longint'(rd_valid), 0);

    // R8: zero iterations
    set_run(7373, 4096, 8192, 4096, 5, 7);
    d0 = done_cnt;
    @(negedge clk); iter_count = '0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(done == 1'b1 && busy == 1'b0, "R8 zero-count done pulse", longint'({done, busy}), 2);
    @(negedge clk);
    check(done == 1'b0, "R8 done lasts one cycle", longint'(done), 0);
    check(amp_idx == 0, "R8 zero-count takes no source sample", amp_idx, 0);

    // R2 R3 R4 R6 R7: plain three-iteration run
    d0 = done_cnt;
    start_run(3);
    wait_done(d0);
    model_run(3);
    @(negedge clk);
    check(done_cnt == d0 + 1 && busy == 1'b0, "R8 single done per run", done_cnt - d0, 1);
    compare_all("R2 R3 R4 R6 R7 basic run");

    // R6 stall, R11 continuation
    feed_en = 1'b0;
    d0 = done_cnt;
    start_run(2);
    repeat (40) @(negedge clk);
    check(busy && src_ready && done_cnt == d0, "R6 waits for source sample",
          longint'({busy, src_ready}), 3);
    feed_en = 1'b1;
    wait_done(d0);
    model_run(2);
    compare_all("R6 R11 stalled continuation");

    // R5 mask, R9 ignored inputs while busy
    for (int r = 3; r <= 8; r++)
      for (int c = 4; c <= 6; c++) load_mask(r*COLS + c, 1'b0);
    set_run(6000, 5000, 7800, 3500, 9, 10);
    d0 = done_cnt;
    start_run(3);
    coef_ca = 16'sd100; coef_db = -16'sd8000; src_row = 4'd2; src_col = 4'd2;
    load_mask(10*COLS + 10, 1'b0);
    @(negedge clk); iter_count = 16'd5; start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_done(d0);
    model_run(3);
    repeat (5) @(negedge clk);
    check(done_cnt == d0 + 1 && busy == 1'b0, "R9 start while busy ignored", done_cnt - d0, 1);
    compare_all("R5 R9 masked run");

    // R6 saturation at border source, R2 clamping with large coefficients
    set_run(32767, 32767, 8192, 16384, 0, 0);
    m_amp_idx = 8;
    @(negedge clk);
    while (amp_idx != 8) begin
      d0 = done_cnt;
      start_run(1);
      wait_done(d0);
      model_run(0);
      break;
    end
    // the source index is already 8 after the previous runs
    check(amp_idx == 8, "R6 sample order", amp_idx, 8);
    d0 = done_cnt;
    start_run(2);
    wait_done(d0);
    model_run(2);
    rd(2, 0, v);
    check(v === 40'(32767), "R6 injection clamps at border cell", longint'(v), 32767);
    compare_all("R2 R3 R4 R6 R7 R11 saturating run");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule